// File: doc/BRIEF.md
# Indirect Jump and Link Unit

This block resolves control transfers whose destination comes from an address register. Each cycle it may receive one decoded operation: a plain jump, a jump that leaves a return address in a link register, or a call. It also receives the contents of the selected source address register and the current program counter. In the same cycle it drives the new program counter, which is the register value with its lowest bit cleared. It also drives a strobe telling the fetch stage to abandon the sequential stream and restart at that target.

A jump-and-link writes the sequential return address, which is the current PC plus 4, into address register 11. A call does not touch that register. Instead it hands the return address to a separate context-save stage through a request strobe, and it pushes the address onto a small return-address stack. The stack holds eight entries. A return path can pop it, and its top entry is visible at the ports. A push into a full stack is discarded and raises an overflow flag in that cycle.

Top module: `ijl_unit`

## Requirements
- R1: For every accepted operation, `redirect_pc` equals `src_addr` with bit 0 forced to 0, in the same cycle as `op_valid`.
- R2: `redirect` is high only in a cycle where `op_valid` is high and `op_kind` is 0 (jump), 1 (jump-and-link) or 2 (call). Code 3 is reserved, and with that code or with `op_valid` low, `redirect`, `link_we` and `call_req` all stay low.
- R3: A jump-and-link (code 1) raises `link_we` with `link_reg` = 11 and `link_data` = `cur_pc` + 4, wrapping modulo 2^32. No other code raises `link_we`.
- R4: A call (code 2) raises `call_req` with `call_ret` = `cur_pc` + 4 and does not raise `link_we`.
- R5: A call pushes `call_ret` onto the return stack, and `ras_top` shows it from the next cycle on. Entries come back in last-in first-out order.
- R6: A call that arrives while the stack holds 8 entries, with no pop in the same cycle, raises `ras_overflow` in that cycle. The pushed value is dropped and the stack contents stay unchanged. The redirect is still issued.
- R7: `ret_pop` removes the top entry, and the new top is visible the next cycle. A pop on an empty stack is ignored: `ras_empty` stays 1 and `ras_top` stays 0.
- R8: A call and a pop in the same cycle replace the top entry with the new return address and leave the depth unchanged. This raises no overflow, even when the stack is full.
- R9: While `rst` is high the stack is emptied. After reset, `ras_empty` = 1 and `ras_top` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe |
| op_kind | input | 2 | 0 jump, 1 jump-and-link, 2 call, 3 reserved |
| src_addr | input | 32 | Source address register value |
| cur_pc | input | 32 | PC of the presented operation |
| ret_pop | input | 1 | Pop request from the return path |
| redirect | output | 1 | Fetch restart strobe |
| redirect_pc | output | 32 | Restart address |
| link_we | output | 1 | Link register write enable |
| link_reg | output | 4 | Link register index (11) |
| link_data | output | 32 | Return address written to the link register |
| call_req | output | 1 | Context-save request |
| call_ret | output | 32 | Return address for the context save |
| ras_top | output | 32 | Top of return stack (0 when empty) |
| ras_empty | output | 1 | Return stack holds no entries |
| ras_overflow | output | 1 | Push dropped because the stack was full |

## Verification
A call and a return-path pop can land in the same cycle. The stack then has to replace its top entry rather than grow. The bench provokes this case on a full stack, where a wrong order of update would either flag an overflow or corrupt the entry below the top. It judges the outcome by requiring that `ras_overflow` stays low in that cycle, that the next cycle shows the new return address on top, and that one further pop exposes the untouched seventh entry.

// File: rtl/ijl_pkg.sv
package ijl_pkg;
  typedef enum logic [1:0] {
    OP_JI    = 2'd0,
    OP_JLI   = 2'd1,
    OP_CALLI = 2'd2,
    OP_RSVD  = 2'd3
  } ijl_op_e;
endpackage

// File: rtl/ijl_decode.sv
module ijl_decode
  import ijl_pkg::*;
(
  input  logic       op_valid,
  input  logic [1:0] op_kind,
  output logic       fire_any,
  output logic       fire_link,
  output logic       fire_call
);
  ijl_op_e kind;

  always_comb begin
    kind      = ijl_op_e'(op_kind);
    fire_any  = 1'b0;
    fire_link = 1'b0;
    fire_call = 1'b0;
    if (op_valid) begin
      unique case (kind)
        OP_JI:    fire_any = 1'b1;
        OP_JLI:   begin fire_any = 1'b1; fire_link = 1'b1; end
        OP_CALLI: begin fire_any = 1'b1; fire_call = 1'b1; end
        default:  fire_any = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/ijl_target.sv
module ijl_target #(
  parameter int AW         = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic [AW-1:0] src_addr,
  input  logic [AW-1:0] cur_pc,
  output logic [AW-1:0] target,
  output logic [AW-1:0] next_pc
);
  localparam logic [AW-1:0] STEP = AW'(INSN_BYTES);

  always_comb begin
    target  = {src_addr[AW-1:1], 1'b0};
    next_pc = cur_pc + STEP;
  end
endmodule

// File: rtl/ijl_ras.sv
module ijl_ras #(
  parameter int AW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] push_data,
  output logic [AW-1:0] top,
  output logic          empty,
  output logic          overflow
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [AW-1:0] mem [DEPTH];
  logic [CW-1:0] count;
  logic [CW-1:0] count_m1;
  logic          full;
  logic          pop_eff;
  logic          replace;
  logic          wr_en;
  logic [IW-1:0] wr_idx;

  always_comb begin
    full     = (count == FULL_CNT);
    empty    = (count == '0);
    count_m1 = count - 1'b1;
    pop_eff  = pop && !empty;
    replace  = push && pop_eff;
    wr_en    = push && (replace || !full);
    wr_idx   = replace ? count_m1[IW-1:0] : count[IW-1:0];
    overflow = push && full && !pop_eff;
    top      = empty ? '0 : mem[count_m1[IW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (replace) begin
      count <= count;
    end else if (wr_en) begin
      count <= count + 1'b1;
    end else if (pop_eff) begin
      count <= count_m1;
    end
  end
endmodule

// File: rtl/ijl_unit.sv
module ijl_unit #(
  parameter int AW         = 32,
  parameter int RAS_DEPTH  = 8,
  parameter int REG_IDX_W  = 4,
  parameter int LINK_REG   = 11,
  parameter int INSN_BYTES = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 op_valid,
  input  logic [1:0]           op_kind,
  input  logic [AW-1:0]        src_addr,
  input  logic [AW-1:0]        cur_pc,
  input  logic                 ret_pop,
  output logic                 redirect,
  output logic [AW-1:0]        redirect_pc,
  output logic                 link_we,
  output logic [REG_IDX_W-1:0] link_reg,
  output logic [AW-1:0]        link_data,
  output logic                 call_req,
  output logic [AW-1:0]        call_ret,
  output logic [AW-1:0]        ras_top,
  output logic                 ras_empty,
  output logic                 ras_overflow
);
  logic          fire_any;
  logic          fire_link;
  logic          fire_call;
  logic [AW-1:0] target;
  logic [AW-1:0] next_pc;

  ijl_decode u_dec (
    .op_valid (op_valid),
    .op_kind  (op_kind),
    .fire_any (fire_any),
    .fire_link(fire_link),
    .fire_call(fire_call)
  );

  ijl_target #(.AW(AW), .INSN_BYTES(INSN_BYTES)) u_tgt (
    .src_addr(src_addr),
    .cur_pc  (cur_pc),
    .target  (target),
    .next_pc (next_pc)
  );

  ijl_ras #(.AW(AW), .DEPTH(RAS_DEPTH)) u_ras (
    .clk      (clk),
    .rst      (rst),
    .push     (fire_call),
    .pop      (ret_pop),
    .push_data(next_pc),
    .top      (ras_top),
    .empty    (ras_empty),
    .overflow (ras_overflow)
  );

  always_comb begin
    redirect    = fire_any;
    redirect_pc = fire_any ? target : '0;
    link_we     = fire_link;
    link_reg    = REG_IDX_W'(LINK_REG);
    link_data   = next_pc;
    call_req    = fire_call;
    call_ret    = next_pc;
  end
endmodule

// File: rtl/ijl_unit_chk.sv
module ijl_unit_chk #(
  parameter int AW         = 32,
  parameter int INSN_BYTES = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          op_valid,
  input logic [1:0]    op_kind,
  input logic [AW-1:0] src_addr,
  input logic [AW-1:0] cur_pc,
  input logic          ret_pop,
  input logic          redirect,
  input logic [AW-1:0] redirect_pc,
  input logic          link_we,
  input logic [AW-1:0] link_data,
  input logic          call_req,
  input logic [AW-1:0] call_ret,
  input logic [AW-1:0] ras_top,
  input logic          ras_empty,
  input logic          ras_overflow
);
  localparam logic [AW-1:0] STEP = AW'(INSN_BYTES);

  p_even_target_r1: assert property (@(posedge clk) disable iff (rst)
    redirect |-> (redirect_pc[0] == 1'b0) && (redirect_pc[AW-1:1] == src_addr[AW-1:1]));

  p_quiet_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (!op_valid || op_kind == 2'd3) |-> (!redirect && !link_we && !call_req));

  p_link_only_jli_r3: assert property (@(posedge clk) disable iff (rst)
    link_we |-> (op_kind == 2'd1) && redirect && (link_data == cur_pc + STEP));

  p_call_ret_r4: assert property (@(posedge clk) disable iff (rst)
    call_req |-> !link_we && redirect && (call_ret == cur_pc + STEP));

  p_push_visible_r5: assert property (@(posedge clk) disable iff (rst)
    (call_req && !ras_overflow) |=> (!ras_empty && ras_top == $past(call_ret)));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    ras_overflow |=> (ras_top == $past(ras_top)) && !ras_empty);

  p_pair_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    (call_req && ret_pop) |-> !ras_overflow);

  p_reset_empty_r9: assert property (@(posedge clk)
    rst |=> ras_empty);
endmodule

bind ijl_unit ijl_unit_chk #(.AW(AW), .INSN_BYTES(INSN_BYTES)) u_chk (.*);

// File: tb/test_ijl_unit.sv
module test_ijl_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic [1:0]  op_kind;
  logic [31:0] src_addr;
  logic [31:0] cur_pc;
  logic        ret_pop;
  logic        redirect;
  logic [31:0] redirect_pc;
  logic        link_we;
  logic [3:0]  link_reg;
  logic [31:0] link_data;
  logic        call_req;
  logic [31:0] call_ret;
  logic [31:0] ras_top;
  logic        ras_empty;
  logic        ras_overflow;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  ijl_unit i_ijl_unit (.*);

  typedef struct packed {
    logic        v;
    logic [1:0]  k;
    logic [31:0] src;
    logic [31:0] pc;
    logic        er;
    logic [31:0] et;
    logic        el;
    logic        ec;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{1'b1, 2'd0, 32'h0000_1235, 32'h0000_0100, 1'b1, 32'h0000_1234, 1'b0, 1'b0},
    '{1'b1, 2'd0, 32'h8000_0000, 32'h0000_0104, 1'b1, 32'h8000_0000, 1'b0, 1'b0},
    '{1'b1, 2'd1, 32'hFFFF_FFFF, 32'h0000_0200, 1'b1, 32'hFFFF_FFFE, 1'b1, 1'b0},
    '{1'b1, 2'd1, 32'h0000_0040, 32'hFFFF_FFFC, 1'b1, 32'h0000_0040, 1'b1, 1'b0},
    '{1'b1, 2'd2, 32'h0000_3001, 32'h0000_0300, 1'b1, 32'h0000_3000, 1'b0, 1'b1},
    '{1'b0, 2'd1, 32'h1111_1111, 32'h0000_0400, 1'b0, 32'h0000_0000, 1'b0, 1'b0},
    '{1'b1, 2'd3, 32'h0000_2223, 32'h0000_0500, 1'b0, 32'h0000_0000, 1'b0, 1'b0},
    '{1'b0, 2'd2, 32'h0000_0055, 32'h0000_0600, 1'b0, 32'h0000_0000, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] k, input logic [31:0] s,
                       input logic [31:0] pc, input logic pop);
    @(negedge clk);
    op_valid = v; op_kind = k; src_addr = s; cur_pc = pc; ret_pop = pop;
    #1;
  endtask

  task automatic idle();
    drive(1'b0, 2'd0, 32'h0, 32'h0, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; op_valid = 1'b0; op_kind = 2'd0; src_addr = '0; cur_pc = '0; ret_pop = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_fail++;
    $display("FAIL watchdog R1..all actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    check("R9 ras_empty after reset", 32'(ras_empty), 32'd1);
    check("R9 ras_top after reset", ras_top, 32'h0);
    check("R2 no redirect after reset", 32'(redirect), 32'd0);

    for (int i = 0; i < 8; i++) begin
      drive(TBL[i].v, TBL[i].k, TBL[i].src, TBL[i].pc, 1'b0);
      check("R2 redirect strobe", 32'(redirect), 32'(TBL[i].er));
      if (TBL[i].er) check("R1 target bit0 cleared", redirect_pc, TBL[i].et);
      check("R3 link write only on jump-and-link", 32'(link_we), 32'(TBL[i].el));
      check("R4 call request", 32'(call_req), 32'(TBL[i].ec));
      if (TBL[i].el) begin
        check("R3 link register index", 32'(link_reg), 32'd11);
        check("R3 link data", link_data, TBL[i].pc + 32'd4);
      end
      if (TBL[i].ec) check("R4 call return address", call_ret, TBL[i].pc + 32'd4);
    end
    idle();
    check("R5 table call pushed", ras_top, 32'h0000_0304);

    do_reset();
    for (int i = 1; i <= 8; i++) begin
      drive(1'b1, 2'd2, 32'h0000_9001, 32'(i) * 32'h100, 1'b0);
      check("R6 no overflow below depth", 32'(ras_overflow), 32'd0);
      idle();
      check("R5 top after push", ras_top, 32'(i) * 32'h100 + 32'd4);
    end
    drive(1'b1, 2'd2, 32'h0000_7777, 32'h0000_0900, 1'b0);
    check("R6 overflow flag on full push", 32'(ras_overflow), 32'd1);
    check("R6 redirect still issued", redirect_pc, 32'h0000_7776);
    idle();
    check("R6 overflow is single cycle", 32'(ras_overflow), 32'd0);
    check("R6 dropped push leaves top", ras_top, 32'h0000_0804);

    drive(1'b1, 2'd2, 32'h0000_4000, 32'h0000_5000, 1'b1);
    check("R8 no overflow on push+pop when full", 32'(ras_overflow), 32'd0);
    idle();
    check("R8 top replaced", ras_top, 32'h0000_5004);
    drive(1'b0, 2'd0, 32'h0, 32'h0, 1'b1);
    idle();
    check("R8 entry below replaced top intact", ras_top, 32'h0000_0704);
    for (int i = 6; i >= 1; i--) begin
      drive(1'b0, 2'd0, 32'h0, 32'h0, 1'b1);
      idle();
      check("R7 LIFO order", ras_top, 32'(i) * 32'h100 + 32'd4);
    end
    drive(1'b0, 2'd0, 32'h0, 32'h0, 1'b1);
    idle();
    check("R7 empty after last pop", 32'(ras_empty), 32'd1);
    drive(1'b0, 2'd0, 32'h0, 32'h0, 1'b1);
    idle();
    check("R7 pop on empty ignored", 32'(ras_empty), 32'd1);
    check("R7 top stays zero", ras_top, 32'h0);

    drive(1'b1, 2'd2, 32'h0000_0A01, 32'h0000_0A00, 1'b1);
    idle();
    check("R8 push+pop on empty acts as push", ras_top, 32'h0000_0A04);
    drive(1'b1, 2'd1, 32'h0000_0B03, 32'h0000_0B00, 1'b0);
    idle();
    check("R3 jump-and-link leaves stack", ras_top, 32'h0000_0A04);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule